// File: doc/BRIEF.md
# Peripheral Protection Access-Permission Resolver

This block holds, for each of ten peripheral protection controllers (PPCs), the per-port mask of peripherals that unprivileged non-secure software may reach. It sits on the non-secure privilege side of the security glue. Software programs it through a small 32-bit register port. Every PPC also has a security mask and a secure-side privilege mask, and both are supplied as input vectors by the secure-side control block. Each port of each PPC gets one registered access-permission bit. When the port is marked non-secure, the bit is taken from the locally held mask. When the port is marked secure, it is taken from the secure-side privilege mask.

The ten PPCs fall into three kinds. There are two internal APB controllers, with 3 ports and 1 port. There are four APB expansion controllers and four AHB expansion controllers, with 16 ports each. In every flat vector each PPC owns a 16-bit slot, and a slot's unused high bits carry no meaning. Reads are combinational from the address. Writes take effect at the clock edge that samples the write strobe.

Top module: `secpriv_resolver`

## Requirements
- R1: For every implemented port b of PPC slot k, the access-permission bit equals the stored non-secure privilege bit b when security input bit b is 1. When that security bit is 0, it equals secure-privilege input bit b.
- R2: A write keeps only a PPC's implemented low bits: 3 bits for slot 0, 1 bit for slot 1 and 16 bits for slots 2 to 9. All higher write-data bits are discarded.
- R3: An access-permission bit above a PPC's port count is always 0, whatever the inputs and the stored mask hold.
- R4: Reset (rst_n low, asynchronous) clears every stored mask and every access-permission output to 0.
- R5: A read returns the addressed PPC's stored mask, zero-extended to 32 bits. Address bits [1:0] are ignored.
- R6: The address map is fixed, and in every group address bits [3:2] select index 0 to 3. Byte offset 0x20 starts the AHB expansion group (slots 6 to 9). Offset 0x30 starts the internal APB group (slots 0 and 1, indices 0 and 1 only). Offset 0x40 starts the APB expansion group (slots 2 to 5).
- R7: Any other offset, including 0x38, 0x3C and 0x00, reads as 0, and a write to it changes no stored mask.
- R8: A write sampled at edge E is visible on a read right after E and reaches the access-permission outputs at edge E+1. A change of either input mask sampled at edge E reaches the outputs at edge E.
- R9: In the flat vectors ns_mask_i, sp_mask_i and ap_o, slot k occupies bits [16k+15:16k], and port b of that PPC is bit 16k+b.
- R10: If a write and an input-mask change are sampled at the same edge, the outputs after that edge combine the new inputs with the old stored mask. One edge later they combine the new inputs with the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ns_mask_i | input | 160 | Per-port security masks, one 16-bit slot per PPC |
| sp_mask_i | input | 160 | Per-port secure-side privilege masks, one 16-bit slot per PPC |
| ap_o | output | 160 | Registered per-port access-permission outputs |

## Verification
Two things can happen in the same cycle: a write to a stored mask, and a change of the security input for the same PPC. These two travel to the outputs with different latencies. The bench drives both in one cycle and checks the read data and ap_o before the edge, just after it, and one edge later. The expected value at each of those points is built from the old or new mask as R8 and R10 dictate. A read issued in the write cycle itself must still return the old mask.

// File: rtl/secpriv_pkg.sv
package secpriv_pkg;

   typedef enum logic [1:0] {
      KIND_INT  = 2'd0,
      KIND_APBX = 2'd1,
      KIND_AHBX = 2'd2
   } ppc_kind_e;

   // Kind of a flat slot: two internal controllers, then APB, then AHB expansion.
   function automatic ppc_kind_e slot_kind(input int slot, input int nexp);
      if (slot < 2)             return KIND_INT;
      else if (slot < 2 + nexp) return KIND_APBX;
      else                      return KIND_AHBX;
   endfunction

   // Implemented port count of a slot.
   function automatic int slot_ports(input int slot, input int nexp,
                                     input int p0, input int p1, input int pe);
      if (slot == 0)      return p0;
      else if (slot == 1) return p1;
      else                return (slot < 2 + 2 * nexp) ? pe : 0;
   endfunction

endpackage

// File: rtl/secpriv_decode.sv
module secpriv_decode #(
   parameter int AW       = 12,
   parameter int NEXP     = 4,
   parameter int GRP_AHBX = 2,
   parameter int GRP_INT  = 3,
   parameter int GRP_APBX = 4,
   parameter int NSLOT    = 2 + 2 * NEXP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   output logic [NSLOT-1:0] sel,
   output logic             hit
);
   localparam int GW = AW - 4;

   logic [1:0]    idx;
   logic [GW-1:0] grp;
   wire           unused_lo = ^addr[1:0];

   assign idx = addr[3:2];
   assign grp = addr[AW-1:4];

   initial begin
      if (NEXP < 1 || NEXP > 4)
         $error("secpriv_decode: NEXP must be 1..4");
      if (GRP_AHBX == GRP_INT || GRP_AHBX == GRP_APBX || GRP_INT == GRP_APBX)
         $error("secpriv_decode: group bases must differ");
      if (NSLOT != 2 + 2 * NEXP)
         $error("secpriv_decode: NSLOT mismatch");
   end

   always_comb begin
      sel = '0;
      if (grp == GW'(GRP_INT) && int'(idx) < 2)
         sel[int'(idx)] = 1'b1;
      if (grp == GW'(GRP_APBX) && int'(idx) < NEXP)
         sel[2 + int'(idx)] = 1'b1;
      if (grp == GW'(GRP_AHBX) && int'(idx) < NEXP)
         sel[2 + NEXP + int'(idx)] = 1'b1;
   end

   assign hit = |sel;

   // R6: an address never selects more than one controller
   a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

endmodule

// File: rtl/secpriv_slice.sv
module secpriv_slice #(
   parameter int PW    = 16,
   parameter int PORTS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_sel,
   input  logic [PW-1:0] wdata,
   input  logic [PW-1:0] ns_in,
   input  logic [PW-1:0] sp_in,
   output logic [PW-1:0] nsp_q,
   output logic [PW-1:0] ap_q
);
   localparam logic [PW-1:0] KEEP = {PW{1'b1}} >> (PW - PORTS);

   logic [PW-1:0] ap_next;

   initial begin
      if (PORTS < 1 || PORTS > PW)
         $error("secpriv_slice: PORTS must be 1..PW");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      nsp_q <= '0;
      else if (wr_sel) nsp_q <= wdata & KEEP;
   end

   for (genvar b = 0; b < PW; b++) begin : g_port
      if (b < PORTS) begin : g_live
         assign ap_next[b] = ns_in[b] ? nsp_q[b] : sp_in[b];
      end else begin : g_tied
         assign ap_next[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ap_q <= '0;
      else        ap_q <= ap_next;
   end

   // R2: a write stores only the implemented bits of the data
   a_r2_write_trim: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> nsp_q == ($past(wdata) & KEEP));
   // R7: the stored mask only moves on a selected write
   a_r7_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel |=> $stable(nsp_q));
   // R3: unimplemented ports stay zero
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_q & ~KEEP) == '0);
   // R4: leaving reset the mask is clear
   a_r4_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (nsp_q == '0 && ap_q == '0));
   // R1: where a port is non-secure and both source bits agree, output follows them
   a_r1_agree: assert property (@(posedge clk) disable iff (!rst_n)
      ((nsp_q & KEEP) == (sp_in & KEEP)) |=> ((ap_q & KEEP) == ($past(nsp_q) & KEEP)));

endmodule

// File: rtl/secpriv_resolver.sv
module secpriv_resolver #(
   parameter int AW         = 12,
   parameter int DW         = 32,
   parameter int PW         = 16,
   parameter int NEXP       = 4,
   parameter int INT0_PORTS = 3,
   parameter int INT1_PORTS = 1,
   parameter int EXP_PORTS  = 16,
   parameter int GRP_AHBX   = 2,
   parameter int GRP_INT    = 3,
   parameter int GRP_APBX   = 4,
   localparam int NSLOT     = 2 + 2 * NEXP,
   localparam int VW        = NSLOT * PW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [VW-1:0] ns_mask_i,
   input  logic [VW-1:0] sp_mask_i,
   output logic [VW-1:0] ap_o
);
   import secpriv_pkg::*;

   logic [NSLOT-1:0] sel;
   logic             hit;
   logic [PW-1:0]    nsp_all [NSLOT];
   wire              unused_hi = ^bus_wdata[DW-1:PW];

   initial begin
      if (PW > DW - 1)
         $error("secpriv_resolver: PW must be below DW");
      if (AW < 8)
         $error("secpriv_resolver: AW too small for the map");
   end

   secpriv_decode #(
      .AW(AW), .NEXP(NEXP), .GRP_AHBX(GRP_AHBX), .GRP_INT(GRP_INT),
      .GRP_APBX(GRP_APBX), .NSLOT(NSLOT)
   ) u_decode (
      .clk  (clk),
      .rst_n(rst_n),
      .addr (bus_addr),
      .sel  (sel),
      .hit  (hit)
   );

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      localparam int PORTS = slot_ports(k, NEXP, INT0_PORTS, INT1_PORTS, EXP_PORTS);
      secpriv_slice #(.PW(PW), .PORTS(PORTS)) u_slice (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_sel(bus_wr & sel[k]),
         .wdata (bus_wdata[PW-1:0]),
         .ns_in (ns_mask_i[k*PW +: PW]),
         .sp_in (sp_mask_i[k*PW +: PW]),
         .nsp_q (nsp_all[k]),
         .ap_q  (ap_o[k*PW +: PW])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NSLOT; k++)
         if (sel[k]) bus_rdata = DW'(nsp_all[k]);
   end

   // R7: a write that misses the map leaves every stored mask alone
   a_r7_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> ($stable(nsp_all[0]) && $stable(nsp_all[1])
                            && $stable(nsp_all[NSLOT-1])));
   // R7: an unmapped read returns zero
   a_r7_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> bus_rdata == '0);

endmodule

// File: tb/secpriv_resolver_tb.sv
`timescale 1ns/1ps
module secpriv_resolver_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [159:0] ns_mask_i = '0;
   logic [159:0] sp_mask_i = '0;
   logic [159:0] ap_o;

   int errors = 0;
   int checks = 0;
   logic [15:0] m_nsp [10];

   always #2.5 clk = ~clk;

   secpriv_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ns_mask_i(ns_mask_i), .sp_mask_i(sp_mask_i), .ap_o(ap_o)
   );

   function automatic int pc(input int k);
      return (k == 0) ? 3 : (k == 1) ? 1 : 16;
   endfunction

   function automatic logic [11:0] addr_of(input int k);
      if (k < 2)      return 12'h030 + 12'(4 * k);
      else if (k < 6) return 12'h040 + 12'(4 * (k - 2));
      else            return 12'h020 + 12'(4 * (k - 6));
   endfunction

   function automatic logic [15:0] keep(input int k);
      return 16'hFFFF >> (16 - pc(k));
   endfunction

   function automatic logic [159:0] calc_ap(input logic [159:0] ns,
                                            input logic [159:0] sp);
      logic [159:0] r = '0;
      for (int k = 0; k < 10; k++)
         for (int b = 0; b < 16; b++)
            if (b < pc(k))
               r[16*k+b] = ns[16*k+b] ? m_nsp[k][b] : sp[16*k+b];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #0.5 chk(tag, 160'(bus_rdata), 160'(exp));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      for (int k = 0; k < 10; k++) m_nsp[k] = '0;
   endtask

   // R4: everything zero out of reset
   task automatic t_reset();
      ns_mask_i = '1; sp_mask_i = '1;
      for (int k = 0; k < 10; k++) rd_chk("R4 reset read", addr_of(k), 32'h0);
      ns_mask_i = '1; sp_mask_i = '0;
      @(posedge clk); @(negedge clk);
      chk("R4 reset ap", ap_o, '0);
   endtask

   // R2, R5, R6: all-ones writes trimmed, map addresses, low bits ignored
   task automatic t_write_map();
      for (int k = 0; k < 10; k++) begin
         wr(addr_of(k), 32'hFFFF_FFFF);
         m_nsp[k] = keep(k);
      end
      for (int k = 0; k < 10; k++)
         rd_chk("R2 R6 trimmed readback", addr_of(k), 32'(m_nsp[k]));
      for (int k = 0; k < 10; k++) begin
         wr(addr_of(k), 32'hABCD_0000 | 32'(16'h1357 ^ 16'(k * 16'h1111)));
         m_nsp[k] = (16'h1357 ^ 16'(k * 16'h1111)) & keep(k);
      end
      rd_chk("R5 read slot6", addr_of(6), 32'(m_nsp[6]));
      rd_chk("R5 addr low bits ignored", addr_of(3) | 12'h3, 32'(m_nsp[3]));
      rd_chk("R5 addr low bits ignored", addr_of(0) | 12'h2, 32'(m_nsp[0]));
   endtask

   // R7: unmapped offsets
   task automatic t_unmapped();
      logic [11:0] holes [5] = '{12'h038, 12'h03C, 12'h000, 12'h050, 12'hFFC};
      foreach (holes[i]) wr(holes[i], 32'hFFFF_FFFF);
      foreach (holes[i]) rd_chk("R7 hole reads zero", holes[i], 32'h0);
      for (int k = 0; k < 10; k++)
         rd_chk("R7 masks untouched", addr_of(k), 32'(m_nsp[k]));
   endtask

   // R1, R3, R9: resolution across patterns
   task automatic t_resolve();
      logic [159:0] pats_ns [4] = '{'1, '0, {10{16'hAAAA}}, {5{32'h0F0F_5A5A}}};
      logic [159:0] pats_sp [4] = '{'0, '1, {10{16'h6666}}, {5{32'hFFFF_0000}}};
      for (int p = 0; p < 4; p++) begin
         @(negedge clk);
         ns_mask_i = pats_ns[p]; sp_mask_i = pats_sp[p];
         @(posedge clk); @(negedge clk);
         chk("R1 R3 R9 resolve", ap_o, calc_ap(ns_mask_i, sp_mask_i));
      end
   endtask

   // R8: latency of writes and of input changes
   task automatic t_timing();
      logic [159:0] old_ap;
      @(negedge clk);
      ns_mask_i = '1; sp_mask_i = '0;
      @(posedge clk); @(negedge clk);
      old_ap = ap_o;
      chk("R8 input change at edge", ap_o, calc_ap(ns_mask_i, sp_mask_i));
      bus_wr = 1'b1; bus_addr = addr_of(4); bus_wdata = 32'h0000_C3A5;
      @(posedge clk);
      #1 bus_wr = 1'b0;
      m_nsp[4] = 16'hC3A5;
      @(negedge clk);
      bus_addr = addr_of(4);
      #0.5 chk("R8 read after write edge", 160'(bus_rdata), 160'h0C3A5);
      chk("R8 ap not yet updated", ap_o, old_ap);
      @(posedge clk); @(negedge clk);
      chk("R8 ap updated one edge later", ap_o, calc_ap(ns_mask_i, sp_mask_i));
   endtask

   // R10: write and input change in the same cycle
   task automatic t_same_cycle();
      logic [159:0] mid;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = addr_of(7); bus_wdata = 32'h0000_00FF;
      #0.5 chk("R10 read in write cycle is old", 160'(bus_rdata), 160'(m_nsp[7]));
      ns_mask_i[16*7 +: 16] = 16'h0FF0;
      sp_mask_i[16*7 +: 16] = 16'hF00F;
      @(posedge clk);
      #1 bus_wr = 1'b0;
      mid = calc_ap(ns_mask_i, sp_mask_i);
      m_nsp[7] = 16'h00FF;
      @(negedge clk);
      chk("R10 new inputs with old mask", ap_o, mid);
      @(posedge clk); @(negedge clk);
      chk("R10 new inputs with new mask", ap_o, calc_ap(ns_mask_i, sp_mask_i));
   endtask

   // R4: asynchronous reset mid-run
   task automatic t_reset_mid();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R4 async reset ap", ap_o, '0);
      for (int k = 0; k < 10; k++) m_nsp[k] = '0;
      chk("R4 async reset read", 160'(bus_rdata), '0);
      @(negedge clk) rst_n = 1'b1;
      rd_chk("R4 mask cleared", addr_of(9), 32'h0);
   endtask

   initial begin
      for (int k = 0; k < 10; k++) m_nsp[k] = '0;
      do_reset();
      t_reset();
      t_write_map();
      t_unmapped();
      t_resolve();
      t_timing();
      t_same_cycle();
      t_reset_mid();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule